// File: doc/BRIEF.md
# Open-Drain Interrupt Request Controller

This block collects event flags from a peripheral's sources (periodic, alarm, update-ended and so on), holds them in a status register, and pulls a shared active-low interrupt line whenever a held flag is matched by its enable bit. The line is never driven high. The block only produces an output-enable: when it is 1 the pad pulls the line to ground, and when it is 0 the pad is high impedance. An external pull-up then lets several devices share one wired request line.

Software sets enable bits over the register bus and reads the status register to find the cause. The read clears every held flag and so releases the line. A synchronous external reset input clears all pending flags and all enable bits, including the periodic enable. It leaves the rest of the peripheral alone. An asynchronous power-on reset puts the block in the same empty state.

Top module: `irq_req_ctrl`

## Requirements
- R1: With `rst_ni` low, all flags and enables are zero, `stat_o` reads 0 and `irq_oe_o` is 0. This also holds when `rst_ni` is pulsed in the middle of operation.
- R2: A 1 on `set_i[i]` at a clock edge sets `stat_o[i]` after that edge, whatever the enable bit. The flag then stays set until it is cleared by a read or a reset.
- R3: `stat_o[NUM_SRC]` (the top bit) is the OR over all i of (flag i AND enable i), and `irq_oe_o` equals that bit.
- R4: While `rd_stb_i` is 1, `stat_o` shows the flags held before the clear. After the clock edge that ends the read, every flag is 0 and `irq_oe_o` is 0, unless R5 applies.
- R5: A `set_i[i]` pulse in the same cycle as `rd_stb_i` leaves flag i set after the edge.
- R6: `ext_rst_i` clears all flags and all enables at the next edge. It wins over a simultaneous `set_i` and over a simultaneous enable write.
- R7: With `en_we_i` high, `en_wdata_i` is loaded into the enables, and `en_o` shows them. Enabling an already-held flag makes `irq_oe_o` 1 after that edge. Clearing the enable makes it 0 after that edge.
- R8: `irq_oe_o` is the only request output: 1 pulls the shared line low and 0 leaves it high impedance. With no enabled flag held, it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| ext_rst_i | input | 1 | Synchronous external reset: clears flags and enables |
| set_i | input | NUM_SRC | Flag-set pulses from event sources (bit 0 periodic, 1 alarm, 2 update-ended) |
| en_we_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | NUM_SRC | Enable register write data |
| rd_stb_i | input | 1 | Status register read strobe (clear on read) |
| stat_o | output | NUM_SRC+1 | Status read data: summary bit on top, flags below |
| en_o | output | NUM_SRC | Current enable bits |
| irq_oe_o | output | 1 | Pad enable: 1 pulls the open-drain request low |

## Verification
The collision that matters is a source pulse arriving in the same cycle as the status read that clears the flags. The stimulus table drives `set_i` and `rd_stb_i` together. After the edge it checks that the new flag survives while the older flags are gone. A second pair is also forced together: external reset against a set pulse and an enable write in one cycle. That vector must leave both registers empty. A directed test samples `stat_o` during the strobe cycle, which confirms that the read sees the values from before the clear.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned IRQ_SRC_DEF = 3;

  typedef enum int unsigned {
    SRC_PERIODIC = 0,
    SRC_ALARM    = 1,
    SRC_UPDATE   = 2
  } irq_src_e;
endpackage

// File: rtl/irq_flag_reg.sv
module irq_flag_reg #(
  parameter int unsigned NUM_SRC = irq_pkg::IRQ_SRC_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ext_rst_i,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic               rd_stb_i,
  output logic [NUM_SRC-1:0] flag_o
);
  logic [NUM_SRC-1:0] flag_q;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flag_q[g] <= 1'b0;
      else if (ext_rst_i) flag_q[g] <= 1'b0;
      else                flag_q[g] <= (flag_q[g] & ~rd_stb_i) | set_i[g];  // set beats clear
    end
  end

  assign flag_o = flag_q;

  p_set_kept_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_rst_i |=> ((flag_q & $past(set_i)) == $past(set_i)));
  p_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ext_rst_i && !rd_stb_i) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));
  p_rd_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stb_i && set_i == '0) |=> (flag_q == '0));
  p_ext_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_rst_i |=> (flag_q == '0));
endmodule

// File: rtl/irq_en_reg.sv
module irq_en_reg #(
  parameter int unsigned NUM_SRC = irq_pkg::IRQ_SRC_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ext_rst_i,
  input  logic               we_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] en_o
);
  logic [NUM_SRC-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        en_q <= '0;
    else if (ext_rst_i) en_q <= '0;
    else if (we_i)      en_q <= wdata_i;
  end

  assign en_o = en_q;

  p_ext_en_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_rst_i |=> (en_q == '0));
  p_wr_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !ext_rst_i) |=> (en_q == $past(wdata_i)));
endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
  parameter int unsigned NUM_SRC = irq_pkg::IRQ_SRC_DEF,
  localparam int unsigned STAT_W = NUM_SRC + 1
) (
  input  logic [NUM_SRC-1:0] flag_i,
  input  logic [NUM_SRC-1:0] en_i,
  output logic [STAT_W-1:0]  stat_o,
  output logic               req_o
);
  logic [NUM_SRC-1:0] act;

  always_comb begin
    act    = flag_i & en_i;
    req_o  = |act;
    stat_o = {req_o, flag_i};
  end
endmodule

// File: rtl/irq_req_ctrl.sv
module irq_req_ctrl #(
  parameter int unsigned NUM_SRC = irq_pkg::IRQ_SRC_DEF,
  localparam int unsigned STAT_W = NUM_SRC + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ext_rst_i,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic               en_we_i,
  input  logic [NUM_SRC-1:0] en_wdata_i,
  input  logic               rd_stb_i,
  output logic [STAT_W-1:0]  stat_o,
  output logic [NUM_SRC-1:0] en_o,
  output logic               irq_oe_o
);
  logic [NUM_SRC-1:0] flag;
  logic [NUM_SRC-1:0] en;

  irq_flag_reg #(.NUM_SRC(NUM_SRC)) u_flag (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ext_rst_i(ext_rst_i),
    .set_i    (set_i),
    .rd_stb_i (rd_stb_i),
    .flag_o   (flag)
  );

  irq_en_reg #(.NUM_SRC(NUM_SRC)) u_en (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ext_rst_i(ext_rst_i),
    .we_i     (en_we_i),
    .wdata_i  (en_wdata_i),
    .en_o     (en)
  );

  irq_combine #(.NUM_SRC(NUM_SRC)) u_comb (
    .flag_i(flag),
    .en_i  (en),
    .stat_o(stat_o),
    .req_o (irq_oe_o)
  );

  assign en_o = en;

  p_idle_hiz_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flag & en) == '0) |-> !irq_oe_o);
  p_en_assert_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_we_i && !ext_rst_i && !rd_stb_i && ((flag & en_wdata_i) != '0)) |=> irq_oe_o);
  p_en_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_we_i && en_wdata_i == '0) |=> !irq_oe_o);
  p_sum_bit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o[NUM_SRC] == irq_oe_o);
endmodule

// File: tb/irq_req_ctrl_bench.sv
module irq_req_ctrl_bench;
  localparam int unsigned N = 3;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         ext_rst = 1'b0;
  logic [N-1:0] set = '0;
  logic         en_we = 1'b0;
  logic [N-1:0] en_wdata = '0;
  logic         rd_stb = 1'b0;
  logic [N:0]   stat;
  logic [N-1:0] en;
  logic         irq_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_req_ctrl #(.NUM_SRC(N)) u_irq_req_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .ext_rst_i(ext_rst), .set_i(set),
    .en_we_i(en_we), .en_wdata_i(en_wdata), .rd_stb_i(rd_stb),
    .stat_o(stat), .en_o(en), .irq_oe_o(irq_oe)
  );

  // {ext, set[3], we, wdata[3], rd, exp_stat[4], exp_irq, exp_en[3]}
  localparam int NV = 11;
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 3'b001, 1'b0, 3'b000, 1'b0, 4'b0001, 1'b0, 3'b000}, // R2 latch without enable
    {1'b0, 3'b000, 1'b1, 3'b001, 1'b0, 4'b1001, 1'b1, 3'b001}, // R7 enable held flag
    {1'b0, 3'b100, 1'b0, 3'b000, 1'b0, 4'b1101, 1'b1, 3'b001}, // R2 second flag
    {1'b0, 3'b000, 1'b0, 3'b000, 1'b1, 4'b0000, 1'b0, 3'b001}, // R4 clear on read
    {1'b0, 3'b010, 1'b0, 3'b000, 1'b1, 4'b0010, 1'b0, 3'b001}, // R5 set during read
    {1'b0, 3'b000, 1'b1, 3'b010, 1'b0, 4'b1010, 1'b1, 3'b010}, // R3 summary
    {1'b0, 3'b000, 1'b1, 3'b000, 1'b0, 4'b0010, 1'b0, 3'b000}, // R7 release
    {1'b1, 3'b001, 1'b1, 3'b111, 1'b0, 4'b0000, 1'b0, 3'b000}, // R6 priority
    {1'b0, 3'b111, 1'b1, 3'b100, 1'b0, 4'b1111, 1'b1, 3'b100}, // R3 all flags
    {1'b0, 3'b000, 1'b0, 3'b000, 1'b0, 4'b1111, 1'b1, 3'b100}, // R2 hold
    {1'b1, 3'b000, 1'b0, 3'b000, 1'b0, 4'b0000, 1'b0, 3'b000}  // R6 plain
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1 reset stat", 8'(stat), 8'h0);
    check("R1 reset en", 8'(en), 8'h0);
    check("R8 idle oe", 8'(irq_oe), 8'h0);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      {ext_rst, set, en_we, en_wdata, rd_stb} = VEC[i][16:8];
      @(negedge clk);
      check($sformatf("R2-R7 vec%0d stat", i), 8'(stat), 8'(VEC[i][7:4]));
      check($sformatf("R3 vec%0d irq", i), 8'(irq_oe), 8'(VEC[i][3]));
      check($sformatf("R7 vec%0d en", i), 8'(en), 8'(VEC[i][2:0]));
    end
    {ext_rst, set, en_we, en_wdata, rd_stb} = '0;

    // R4: read data shows pre-clear flags during the strobe cycle
    set = 3'b101; en_we = 1'b1; en_wdata = 3'b100;
    @(negedge clk);
    set = '0; en_we = 1'b0; rd_stb = 1'b1;
    #1;
    check("R4 read pre-clear", 8'(stat), 8'b1101);
    @(negedge clk);
    rd_stb = 1'b0;
    check("R4 after read", 8'(stat), 8'h0);
    check("R8 released", 8'(irq_oe), 8'h0);

    // R1: asynchronous reset mid-run
    set = 3'b011; en_we = 1'b1; en_wdata = 3'b011;
    @(negedge clk);
    set = '0; en_we = 1'b0;
    check("R3 before reset", 8'(irq_oe), 8'h1);
    rst_ni = 1'b0;
    #1;
    check("R1 async stat", 8'(stat), 8'h0);
    check("R1 async en", 8'(en), 8'h0);
    check("R1 async oe", 8'(irq_oe), 8'h0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule